// File: doc/BRIEF.md
# Edge-Detecting GPIO Controller

This block is a 28-pin general-purpose I/O controller with a small word-addressed register bus. Software chooses per pin whether it drives or listens. Output levels are changed through separate set and clear registers, so a bit can change without a read-modify-write. Input pins pass through a two-flop synchroniser. After that, rising and falling transitions can be latched into a sticky status register. Software clears that register by writing ones.

The first eleven pins each raise their own interrupt line from their status bit. All the remaining pins share one combined line. An alternate-function word is kept in a register for neighbouring pad logic and is read back. It has no effect inside the block. Reads return data one clock after the read strobe.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every pin is an input and all registers read 0. This covers the direction, set readback, edge enables, edge status and alternate-function registers. `pin_out`, `irq_pin` and `irq_upper` are all 0.
- R2: A write to the set register (word 2) drives high every latch bit written as 1, and bits written as 0 keep their value. Reading word 2 returns the last value written there.
- R3: A write to the clear register (word 3) drives low every latch bit written as 1, and bits written as 0 keep their value. Reading word 3 returns 0.
- R4: `pin_out` equals the output latch ANDed with the direction register, registered once. A direction bit of 1 means output, and 0 means input.
- R5: Reading the level register (word 0) returns the latch bit for output pins and the synchronised input for input pins.
- R6: A 0-to-1 transition between consecutive synchronised samples sets the status bit when the rising-enable bit (word 4) is 1 and the pin is an input. A change on `pin_in` is visible in status three clock edges later.
- R7: A 1-to-0 transition sets the status bit under the same rules, using the falling-enable register (word 5).
- R8: A transition leaves status unchanged when the pin is an output or when the matching enable bit is 0.
- R9: Writing 1 to a status bit (word 6) clears it, and writing 0 has no effect. If a new edge on a bit arrives in the same cycle as its clear, the edge wins and the bit stays set.
- R10: `irq_pin[i]` for i in 0..10 follows status bit i, one clock later.
- R11: `irq_upper` is the OR of status bits 11..27, one clock later.
- R12: The alternate-function register (word 7) stores and returns all 28 bits and changes no other register or output.
- R13: The register words are: level 0, direction 1, set 2, clear 3, rising enable 4, falling enable 5, status 6, alternate function 7. A read strobe returns data on `bus_rd_data` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word index |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 28 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 28 | Registered read data |
| pin_in | input | 28 | Asynchronous pin inputs |
| pin_out | output | 28 | Driven pin values (latch AND direction) |
| irq_pin | output | 11 | Per-pin interrupts for pins 0..10 |
| irq_upper | output | 1 | Combined interrupt for pins 11..27 |

## Verification
Two functions can meet on one status bit in the same cycle: an edge setting the bit and a software write clearing it. The bench provokes this by raising an enabled input two cycles before it issues a status write. That places the edge's registration and the clear on the same clock edge. The same write also clears a second bit that was already pending. The status must then show the new edge kept and the old bit gone, and the per-pin interrupt lines must show the same pattern.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned REG_IDX_W = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    REG_LEVEL = 3'd0,
    REG_DIR   = 3'd1,
    REG_SET   = 3'd2,
    REG_CLR   = 3'd3,
    REG_RISE  = 3'd4,
    REG_FALL  = 3'd5,
    REG_STAT  = 3'd6,
    REG_ALT   = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int unsigned W      = 28,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int unsigned W = 28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sample_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] clr_mask_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] status_q;
  logic [W-1:0] rise_hit;
  logic [W-1:0] fall_hit;
  logic [W-1:0] any_hit;

  always_comb begin
    rise_hit = sample_i & ~prev_q & rise_en_i & ~dir_i;
    fall_hit = ~sample_i & prev_q & fall_en_i & ~dir_i;
    any_hit  = rise_hit | fall_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= sample_i;
      // a fresh edge outranks a clear aimed at the same bit
      status_q <= (status_q & ~clr_mask_i) | any_hit;
    end
  end

  assign status_o = status_q;

  assert_no_status_on_output_R8: assert property (@(posedge clk) disable iff (rst)
    ((status_q & ~$past(status_q) & $past(dir_i)) == '0));

  assert_no_status_when_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    ((status_q & ~$past(status_q) & ~$past(rise_en_i) & ~$past(fall_en_i)) == '0));

  assert_clear_honoured_R9: assert property (@(posedge clk) disable iff (rst)
    ((status_q & $past(clr_mask_i) & ~$past(any_hit)) == '0));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int unsigned W    = 28,
  parameter int unsigned NDED = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    status_i,
  output logic [NDED-1:0] irq_pin_o,
  output logic            irq_upper_o
);
  for (genvar i = 0; i < NDED; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) irq_pin_o[i] <= 1'b0;
      else     irq_pin_o[i] <= status_i[i];
    end
  end

  assert_irq_follows_status_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_pin_o == $past(status_i[NDED-1:0])));

  if (W > NDED) begin : g_upper
    logic upper_q;
    always_ff @(posedge clk) begin
      if (rst) upper_q <= 1'b0;
      else     upper_q <= |status_i[W-1:NDED];
    end
    assign irq_upper_o = upper_q;

    assert_upper_irq_R11: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (irq_upper_o == $past(|status_i[W-1:NDED])));
  end else begin : g_no_upper
    assign irq_upper_o = 1'b0;
  end
endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
  import gpio_edge_pkg::*;
#(
  parameter int unsigned W = 28
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [REG_IDX_W-1:0] addr_i,
  input  logic                 wr_en_i,
  input  logic [W-1:0]         wr_data_i,
  input  logic                 rd_en_i,
  output logic [W-1:0]         rd_data_o,
  input  logic [W-1:0]         sample_i,
  input  logic [W-1:0]         status_i,
  output logic [W-1:0]         dir_o,
  output logic [W-1:0]         rise_en_o,
  output logic [W-1:0]         fall_en_o,
  output logic [W-1:0]         clr_mask_o,
  output logic [W-1:0]         pin_out_o
);
  reg_sel_e     sel;
  logic [W-1:0] latch_q, dir_q, rise_q, fall_q, alt_q, set_shadow_q;
  logic [W-1:0] rd_mux;
  logic [W-1:0] level;

  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q      <= '0;
      dir_q        <= '0;
      rise_q       <= '0;
      fall_q       <= '0;
      alt_q        <= '0;
      set_shadow_q <= '0;
    end else if (wr_en_i) begin
      unique case (sel)
        REG_DIR:  dir_q <= wr_data_i;
        REG_SET: begin
          latch_q      <= latch_q | wr_data_i;
          set_shadow_q <= wr_data_i;
        end
        REG_CLR:  latch_q <= latch_q & ~wr_data_i;
        REG_RISE: rise_q  <= wr_data_i;
        REG_FALL: fall_q  <= wr_data_i;
        REG_ALT:  alt_q   <= wr_data_i;
        default: ;
      endcase
    end
  end

  assign clr_mask_o = (wr_en_i && sel == REG_STAT) ? wr_data_i : '0;

  always_comb begin
    level = (latch_q & dir_q) | (sample_i & ~dir_q);
    unique case (sel)
      REG_LEVEL: rd_mux = level;
      REG_DIR:   rd_mux = dir_q;
      REG_SET:   rd_mux = set_shadow_q;
      REG_CLR:   rd_mux = '0;
      REG_RISE:  rd_mux = rise_q;
      REG_FALL:  rd_mux = fall_q;
      REG_STAT:  rd_mux = status_i;
      REG_ALT:   rd_mux = alt_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
      pin_out_o <= '0;
    end else begin
      if (rd_en_i) rd_data_o <= rd_mux;
      pin_out_o <= latch_q & dir_q;
    end
  end

  assign dir_o     = dir_q;
  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;

  assert_set_drives_high_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && sel == REG_SET) |=> ((latch_q & $past(wr_data_i)) == $past(wr_data_i)));

  assert_clear_drives_low_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && sel == REG_CLR) |=> ((latch_q & $past(wr_data_i)) == '0));

  assert_pin_out_masked_R4: assert property (@(posedge clk) disable iff (rst)
    ((pin_out_o & ~$past(dir_q)) == '0));

  assert_alt_isolated_R12: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && sel == REG_ALT) |=> ($stable(latch_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NUM_PINS      = 28,
  parameter int unsigned NUM_DEDICATED = 11,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [REG_IDX_W-1:0]     bus_addr,
  input  logic                     bus_wr_en,
  input  logic [NUM_PINS-1:0]      bus_wr_data,
  input  logic                     bus_rd_en,
  output logic [NUM_PINS-1:0]      bus_rd_data,
  input  logic [NUM_PINS-1:0]      pin_in,
  output logic [NUM_PINS-1:0]      pin_out,
  output logic [NUM_DEDICATED-1:0] irq_pin,
  output logic                     irq_upper
);
  logic [NUM_PINS-1:0] sample, dir, rise_en, fall_en, clr_mask, status;

  gpio_edge_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(pin_in), .sync_o(sample)
  );

  gpio_edge_regs #(.W(NUM_PINS)) u_regs (
    .clk(clk), .rst(rst),
    .addr_i(bus_addr), .wr_en_i(bus_wr_en), .wr_data_i(bus_wr_data),
    .rd_en_i(bus_rd_en), .rd_data_o(bus_rd_data),
    .sample_i(sample), .status_i(status),
    .dir_o(dir), .rise_en_o(rise_en), .fall_en_o(fall_en),
    .clr_mask_o(clr_mask), .pin_out_o(pin_out)
  );

  gpio_edge_detect #(.W(NUM_PINS)) u_detect (
    .clk(clk), .rst(rst), .sample_i(sample), .dir_i(dir),
    .rise_en_i(rise_en), .fall_en_i(fall_en), .clr_mask_i(clr_mask),
    .status_o(status)
  );

  gpio_edge_irq #(.W(NUM_PINS), .NDED(NUM_DEDICATED)) u_irq (
    .clk(clk), .rst(rst), .status_i(status),
    .irq_pin_o(irq_pin), .irq_upper_o(irq_upper)
  );
endmodule

// File: tb/gpio_edge_ctrl_test.sv
module gpio_edge_ctrl_test;
  localparam int unsigned NP = 28;
  localparam int unsigned ND = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    bus_addr = '0;
  logic          bus_wr_en = 1'b0;
  logic [NP-1:0] bus_wr_data = '0;
  logic          bus_rd_en = 1'b0;
  logic [NP-1:0] bus_rd_data;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [ND-1:0] irq_pin;
  logic          irq_upper;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [NP-1:0] rv;

  gpio_edge_ctrl uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
    .pin_in(pin_in), .pin_out(pin_out), .irq_pin(irq_pin), .irq_upper(irq_upper)
  );

  always #10 clk = ~clk;

  localparam logic [2:0] W_LEVEL = 3'd0, W_DIR = 3'd1, W_SET = 3'd2, W_CLR = 3'd3,
                         W_RISE = 3'd4, W_FALL = 3'd5, W_STAT = 3'd6, W_ALT = 3'd7;

  typedef struct packed {
    logic [2:0]    wa;
    logic [NP-1:0] wd;
    logic [2:0]    ra;
    logic [NP-1:0] exp;
    logic [3:0]    req;
  } vec_t;

  // pin_in held at 0x0AAAAAAA while the table runs
  localparam vec_t VECS [8] = '{
    '{3'd1, 28'h00FF00FF, 3'd1, 28'h00FF00FF, 4'd13}, // R13 direction word
    '{3'd2, 28'h0F0F0F0F, 3'd2, 28'h0F0F0F0F, 4'd2},  // R2 set readback
    '{3'd7, 28'h01234567, 3'd0, 28'h0A0FAA0F, 4'd5},  // R5 level mux
    '{3'd3, 28'h00000003, 3'd3, 28'h00000000, 4'd3},  // R3 clear reads 0
    '{3'd7, 28'h0ABCDEF0, 3'd7, 28'h0ABCDEF0, 4'd12}, // R12 alt readback
    '{3'd2, 28'h00000000, 3'd0, 28'h0A0FAA0C, 4'd3},  // R3 clear took effect, zero set is no-op
    '{3'd4, 28'h0000F0F0, 3'd4, 28'h0000F0F0, 4'd13}, // R13 rising word
    '{3'd5, 28'h00000F0F, 3'd5, 28'h00000F0F, 4'd13}  // R13 falling word
  };

  task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [NP-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    check("R1 pin_out", pin_out, '0);
    check("R1 irq_pin", NP'(irq_pin), '0);
    check("R1 irq_upper", NP'(irq_upper), '0);
    for (int r = 0; r < 8; r++) begin
      rd(3'(r), rv);
      check($sformatf("R1 word %0d", r), rv, '0);
    end

    pin_in = 28'h0AAAAAAA;
    idle(4);
    for (int k = 0; k < 8; k++) begin
      wr(VECS[k].wa, VECS[k].wd);
      rd(VECS[k].ra, rv);
      check($sformatf("R%0d table %0d", VECS[k].req, k), rv, VECS[k].exp);
    end
    check("R4 pin_out", pin_out, 28'h000F000C);
    rd(W_STAT, rv);
    check("R8 static pins give no status", rv, '0);

    // edge section
    wr(W_DIR, '0); wr(W_CLR, 28'h0FFFFFFF); wr(W_RISE, '0); wr(W_FALL, '0);
    pin_in = 28'h0000_0020;
    idle(4);
    wr(W_RISE, (28'h1 << 3) | (28'h1 << 4) | (28'h1 << 7) | (28'h1 << 20));
    wr(W_FALL, 28'h1 << 5);
    wr(W_DIR, 28'h1 << 7);
    rd(W_STAT, rv);
    check("R8 setup quiet", rv, '0);

    pin_in[3] = 1'b1; idle(4);
    rd(W_STAT, rv);
    check("R6 rising pin3", rv, 28'h8);
    check("R10 irq_pin3", NP'(irq_pin), 28'h8);

    pin_in[5] = 1'b0; idle(4);
    rd(W_STAT, rv);
    check("R7 falling pin5", rv, 28'h28);

    pin_in[7] = 1'b1; pin_in[9] = 1'b1; idle(4);
    rd(W_STAT, rv);
    check("R8 output pin / disabled pin", rv, 28'h28);

    pin_in[20] = 1'b1; idle(4);
    check("R11 irq_upper set", NP'(irq_upper), 28'h1);
    check("R10 lower lines", NP'(irq_pin), 28'h28);
    rd(W_STAT, rv);
    check("R6 rising pin20", rv, 28'h100028);

    wr(W_STAT, 28'h100020); idle(2);
    rd(W_STAT, rv);
    check("R9 write-one clear", rv, 28'h8);
    check("R11 irq_upper cleared", NP'(irq_upper), '0);
    check("R10 irq after clear", NP'(irq_pin), 28'h8);

    // R9 edge and clear on the same clock edge
    @(negedge clk); pin_in[4] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = W_STAT; bus_wr_data = 28'h18; bus_wr_en = 1'b1;
    @(negedge clk); bus_wr_en = 1'b0;
    rd(W_STAT, rv);
    check("R9 edge beats clear", rv, 28'h10);
    idle(1);
    check("R10 irq after coincidence", NP'(irq_pin), 28'h10);

    // R1 reset in mid-run
    wr(W_SET, 28'h0FFFFFFF); wr(W_DIR, 28'h0000FFFF); wr(W_ALT, 28'h5);
    @(negedge clk); rst = 1'b1; idle(2); rst = 1'b0; idle(3);
    check("R1 pin_out after reset", pin_out, '0);
    check("R1 irq after reset", NP'({irq_upper, irq_pin}), '0);
    rd(W_DIR, rv);  check("R1 dir after reset", rv, '0);
    rd(W_SET, rv);  check("R1 set after reset", rv, '0);
    rd(W_ALT, rv);  check("R1 alt after reset", rv, '0);
    rd(W_STAT, rv); check("R1 status after reset", rv, '0);
    rd(W_LEVEL, rv); check("R5 level shows inputs", rv, pin_in);

    finish_run();
  end
endmodule